// File: doc/BRIEF.md
# Positional Insert/Delete Register Queue

This block keeps a short ordered list of data words in a bank of registers. Unlike a plain FIFO, a request may insert a new word at any chosen slot, or delete the word in any chosen slot. Entries above the chosen slot slide one place up to open a gap on insert, or one place down to close it on delete. Slots below the chosen slot keep their contents.

The occupied slots always run from slot 0 upward without holes. The highest occupied slot is the head, and the head word is shown on the output bus at all times. A controller tracks the occupancy level with one state per level, from empty to full. It rejects any request that cannot be carried out, and reports each rejection as a one-cycle error pulse. A rejected request leaves the stored words and the occupancy unchanged.

Top module: `positional_queue`

## Requirements
- R1: While `rst_n` is low, and after it is released, `count` is 0, `head_data` is 0 and `err` is 0.
- R2: A legal insert (`ins_req`=1, `del_req`=0, `count` < DEPTH, `pos` <= `count`) writes `wr_data` into slot `pos`. Each occupied slot at or above `pos` moves one place higher, slots below `pos` are unchanged, and `count` rises by one at the next clock edge.
- R3: A legal delete (`del_req`=1, `ins_req`=0, `count` > 0, `pos` < `count`) discards slot `pos`. Each occupied slot above `pos` moves one place lower, slots below `pos` are unchanged, and `count` falls by one at the next clock edge.
- R4: `head_data` always equals the word in slot `count`-1, and it is 0 when `count` is 0.
- R5: An insert while `count` equals DEPTH is rejected: `err` is 1 in the following cycle, and the contents and `count` are unchanged.
- R6: A delete while `count` is 0 is rejected: `err` is 1 in the following cycle, and the contents and `count` are unchanged.
- R7: `ins_req` and `del_req` both high in the same cycle is rejected: `err` is 1 in the following cycle, and neither operation takes place.
- R8: An insert with `pos` > `count`, or a delete with `pos` >= `count`, is rejected: `err` is 1 in the following cycle, and the contents and `count` are unchanged.
- R9: `err` is a registered pulse. It is high only in the cycle after a rejected request, and low after a cycle with a legal request or no request.
- R10: `count` never exceeds DEPTH, and it changes only by one step per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Word to insert |
| ins_req | input | 1 | Insert request |
| del_req | input | 1 | Delete request |
| pos | input | $clog2(DEPTH) | Target slot index |
| head_data | output | DATA_W | Word in the head slot, 0 when empty |
| count | output | $clog2(DEPTH+1) | Number of occupied slots |
| err | output | 1 | One-cycle pulse marking a rejected request |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=12. A four-slot bank can be driven to every occupancy level, and every slot index can be targeted, within a few requests. The 12-bit random words make a misplaced or stale entry show up on the head bus. Random positional inserts and deletes slide words across every slot boundary, so a wrong shift direction or a wrong start slot surfaces when the word later reaches the head. Directed runs fill and drain the bank to reach the full, empty, both-requests and out-of-range rejections.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_INS  = 2'd1,
    OP_DEL  = 2'd2
  } rq_op_e;
endpackage

// File: rtl/rq_ctrl.sv
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int POS_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_req,
  input  logic             del_req,
  input  logic [POS_W-1:0] pos,
  output rq_op_e           op,
  output logic [CNT_W-1:0] count,
  output logic             err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] lvl_q, lvl_d;
  logic             err_d;
  logic [CNT_W-1:0] pos_ext;

  assign pos_ext = CNT_W'(pos);

  // Legality decode and next occupancy level
  always_comb begin
    op    = OP_NONE;
    lvl_d = lvl_q;
    err_d = 1'b0;
    if (ins_req && del_req) begin
      err_d = 1'b1;
    end else if (ins_req) begin
      if (lvl_q != FULL && pos_ext <= lvl_q) begin
        op    = OP_INS;
        lvl_d = lvl_q + 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end else if (del_req) begin
      if (lvl_q != '0 && pos_ext < lvl_q) begin
        op    = OP_DEL;
        lvl_d = lvl_q - 1'b1;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      err   <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      err   <= err_d;
    end
  end

  assign count = lvl_q;
endmodule

// File: rtl/rq_slot.sv
module rq_slot
  import rq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS_W  = 2,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rq_op_e            op,
  input  logic [POS_W-1:0]  pos,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] from_below,
  input  logic [DATA_W-1:0] from_above,
  output logic [DATA_W-1:0] q
);
  localparam logic [POS_W-1:0] MY_IDX = POS_W'(IDX);

  logic              en;
  logic [DATA_W-1:0] d;

  // A slot at or above the target index takes part in every shift
  always_comb begin
    en = (op != OP_NONE) && (pos <= MY_IDX);
    d  = q;
    if (op == OP_INS) d = (pos == MY_IDX) ? wr_data : from_below;
    else if (op == OP_DEL) d = from_above;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/positional_queue.sv
module positional_queue
  import rq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int POS_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ins_req,
  input  logic              del_req,
  input  logic [POS_W-1:0]  pos,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              err
);
  rq_op_e            op;
  logic [DATA_W-1:0] slot_q [DEPTH];

  rq_ctrl #(.DEPTH(DEPTH), .POS_W(POS_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_req (ins_req),
    .del_req (del_req),
    .pos     (pos),
    .op      (op),
    .count   (count),
    .err     (err)
  );

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [DATA_W-1:0] below, above;
    if (j == 0) begin : g_bot
      assign below = wr_data;
    end else begin : g_mid_lo
      assign below = slot_q[j-1];
    end
    if (j == DEPTH - 1) begin : g_top
      assign above = '0;
    end else begin : g_mid_hi
      assign above = slot_q[j+1];
    end
    rq_slot #(.DATA_W(DATA_W), .POS_W(POS_W), .IDX(j)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .pos        (pos),
      .wr_data    (wr_data),
      .from_below (below),
      .from_above (above),
      .q          (slot_q[j])
    );
  end

  // Head is slot count-1; the bus reads zero when nothing is stored
  always_comb begin
    head_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (count == CNT_W'(k + 1)) head_data = slot_q[k];
    end
  end
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int POS_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_req,
  input logic              del_req,
  input logic [POS_W-1:0]  pos,
  input logic [DATA_W-1:0] head_data,
  input logic [CNT_W-1:0]  count,
  input logic              err
);
  logic ins_ok, del_ok, bad;
  assign ins_ok = ins_req && !del_req && (count < CNT_W'(DEPTH)) && (CNT_W'(pos) <= count);
  assign del_ok = del_req && !ins_req && (count != '0) && (CNT_W'(pos) < count);
  assign bad    = (ins_req || del_req) && !ins_ok && !del_ok;

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_ins_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> count == $past(count) + 1'b1);
  assert_del_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    del_ok |=> count == $past(count) - 1'b1);
  assert_empty_head_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (head_data == '0));
  assert_reject_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err && $stable(count));
  assert_no_spurious_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !err);
  assert_both_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && del_req) |=> $stable(count));
endmodule

bind positional_queue rq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_req   (ins_req),
  .del_req   (del_req),
  .pos       (pos),
  .head_data (head_data),
  .count     (count),
  .err       (err)
);

// File: tb/test_positional_queue.sv
module test_positional_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 4;
  localparam int POS_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic ins_req = 1'b0, del_req = 1'b0;
  logic [POS_W-1:0] pos = '0;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0] count;
  logic err;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  int mcnt = 0;
  logic [DATA_W-1:0] m [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  positional_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_positional_queue (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .ins_req(ins_req),
    .del_req(del_req), .pos(pos), .head_data(head_data), .count(count), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string classify(input bit i, input bit d, input int p);
    if (i && d) return "R7";
    if (i && mcnt == DEPTH) return "R5";
    if (d && mcnt == 0) return "R6";
    if (i && p > mcnt) return "R8";
    if (d && p >= mcnt) return "R8";
    if (i) return "R2";
    if (d) return "R3";
    return "R9";
  endfunction

  task automatic do_op(input bit i, input bit d, input int p, input logic [DATA_W-1:0] w);
    string tag;
    bit    exp_err;
    int    exp_head;
    tag = classify(i, d, p);
    exp_err = (tag == "R5" || tag == "R6" || tag == "R7" || tag == "R8");
    @(negedge clk);
    ins_req = i; del_req = d; pos = POS_W'(p); wr_data = w;
    @(posedge clk);
    #1;
    if (tag == "R2") begin
      for (int j = mcnt; j > p; j--) m[j] = m[j-1];
      m[p] = w;
      mcnt++;
    end else if (tag == "R3") begin
      for (int j = p; j < mcnt - 1; j++) m[j] = m[j+1];
      mcnt--;
    end
    exp_head = (mcnt == 0) ? 0 : int'(m[mcnt-1]);
    chk(int'(count) == mcnt, {tag, " count R10"}, int'(count), mcnt);
    chk(int'(head_data) == exp_head, {tag, " head R4"}, int'(head_data), exp_head);
    chk(err == exp_err, {tag, " err R9"}, int'(err), int'(exp_err));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int j = 0; j < DEPTH; j++) m[j] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(count == 0, "R1 count in reset", int'(count), 0);
    chk(head_data == 0, "R1 head in reset", int'(head_data), 0);
    chk(err == 0, "R1 err in reset", int'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(count == 0 && head_data == 0 && err == 0, "R1 after release", int'(count), 0);

    // Directed corners
    do_op(0, 1, 0, 12'h000);          // R6 delete empty
    do_op(0, 0, 0, 12'h000);          // R9 error clears
    do_op(1, 0, 1, 12'h111);          // R8 insert beyond count
    do_op(1, 0, 0, 12'hA01);          // R2
    do_op(1, 0, 0, 12'hA02);          // R2 insert below, head unchanged
    do_op(1, 0, 2, 12'hA03);          // R2 insert at top
    do_op(1, 0, 1, 12'hA04);          // R2 middle
    do_op(1, 0, 0, 12'hBAD);          // R5 full
    do_op(1, 1, 1, 12'hBAD);          // R7 both
    do_op(0, 1, 1, 12'h000);          // R3 middle
    do_op(0, 1, 3, 12'h000);          // R8 delete at count
    do_op(0, 1, 2, 12'h000);          // R3 head delete
    do_op(0, 1, 0, 12'h000);          // R3 bottom
    do_op(0, 1, 0, 12'h000);          // R3 last
    do_op(0, 0, 0, 12'h000);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r, p;
      bit i, d;
      r = int'($urandom_range(0, 99));
      i = (r < 45) || (r >= 95);
      d = (r >= 45 && r < 85) || (r >= 95);
      if ($urandom_range(0, 9) < 8)
        p = (mcnt == 0) ? 0 : int'($urandom_range(0, (i ? mcnt : mcnt - 1) < DEPTH - 1 ?
                                                     (i ? mcnt : mcnt - 1) : DEPTH - 1));
      else
        p = int'($urandom_range(0, DEPTH - 1));
      do_op(i, d, p, DATA_W'($urandom));
    end

    @(negedge clk);
    ins_req = 0; del_req = 0;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule